// File: doc/BRIEF.md
# Strap-Selected Parallel Host Register Port

This block sits between an 8-bit microcontroller bus and a DSP core. The host reaches four byte-wide registers through two address lines, an active-low select and two control pins. The meaning of the control pins is decided once per reset by a strap input. With one level the pins act as a read enable and a write strobe. With the other level they act as a direction line and a data strobe. Once the choice is made, the strap pin becomes a general-purpose I/O bit that the host controls through one of the four registers.

On the DSP side the core posts a byte for the host (the outbox) and collects bytes the host has sent (the inbox). While an outbox byte is waiting, the port pulls its interrupt-request line low, and a host read of the outbox releases it. The control pins pass through a synchronizer before the host access machine sees them. The machine has four named states. S_STRAP is entered on reset and latches the style. S_IDLE waits for an access, and a write wins if both qualifiers are seen at once. S_WRITE tracks a write and leaves it when the strobe ends, which commits the byte. S_READ tracks a read and leaves it when the read qualifier ends, which finishes the read. The transitions are STRAP→IDLE on the first clock after reset, IDLE→WRITE, IDLE→READ, WRITE→IDLE and READ→IDLE. The data bus is split into an input, an output and an output enable for the pad.

Top module: `hpp_host_port`

## Requirements
- R1: While rst_n is low, hd_oe and strap_oe are 0 and irq_pull_low is 0 for any pin state. After reset, all four registers read as zero, apart from the pin-level bit of register 3.
- R2: The level of strap_i on the first clock after rst_n rises picks the style: 0 means split strobes and 1 means direction plus strobe. Later changes of strap_i do not alter the style.
- R3: In the split style, hctl_b low with hcs_n low is a write, and the byte is committed when hctl_b rises. The register shows the byte 3 clocks after that rise.
- R4: In the split style, hd_oe is 1 exactly while hcs_n and hctl_a are both low, and hd_o shows the register selected by ha.
- R5: In the direction style, with hcs_n low and hctl_b low, hctl_a high is a read (hd_oe 1) and hctl_a low is a write, committed when hctl_b rises.
- R6: With hcs_n high, no write is committed and hd_oe stays 0.
- R7: Register 0 is the outbox and is read-only to the host. Register 1 is the inbox byte and can be read back. Register 2 is status, read-only: bit 0 is outbox pending and bit 1 is inbox full. Register 3 is GPIO control: bit 0 is the output value, bit 1 is the output enable, and bit 2 is the strap_i level, which is read-only.
- R8: dsp_out_wr loads dsp_out_data into the outbox and sets pending on the next clock. irq_pull_low equals pending.
- R9: A completed host read of register 0 clears pending. If dsp_out_wr is asserted in the same clock, pending stays set and the new byte is stored.
- R10: A host write of register 1 sets inbox full, with the byte on dsp_in_data. dsp_in_ack clears the flag, but a host commit in the same clock wins.
- R11: strap_o follows register 3 bit 0 and strap_oe follows register 3 bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 8 | Host data bus, pad input |
| hd_o | output | 8 | Host data bus, pad output |
| hd_oe | output | 1 | Host data bus output enable |
| ha | input | 2 | Host register address |
| hcs_n | input | 1 | Active-low chip select |
| hctl_a | input | 1 | Read enable (split) or direction (direction style) |
| hctl_b | input | 1 | Write strobe (split) or data strobe (direction style) |
| strap_i | input | 1 | Style strap at reset, GPIO input afterwards |
| strap_o | output | 1 | GPIO output value |
| strap_oe | output | 1 | GPIO output enable |
| irq_pull_low | output | 1 | Drive the open-drain interrupt request low |
| dsp_out_wr | input | 1 | DSP posts an outbox byte |
| dsp_out_data | input | 8 | Outbox byte from the DSP |
| dsp_in_ack | input | 1 | DSP has taken the inbox byte |
| dsp_in_data | output | 8 | Inbox byte for the DSP |
| dsp_in_full | output | 1 | Inbox holds an unread byte |

## Verification
Read data and hd_oe come straight from the pins, with no clock in between, so the bench samples them 1 ns after it sets the pins in mid-cycle. A host write or the end of a host read takes effect on the third rising edge after the strobe is released: two edges for the synchronizer and one for the state register. Each host task therefore waits five cycles after a release before it reads anything back. DSP-side inputs are registered once, so irq_pull_low and the status bits are checked on the negative edge after the next rising edge. The same-clock race between a DSP post and the end of a read is hit by asserting dsp_out_wr in the cycle that ends with that third edge.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
    typedef enum logic [1:0] {
        S_STRAP = 2'd0,
        S_IDLE  = 2'd1,
        S_WRITE = 2'd2,
        S_READ  = 2'd3
    } hst_state_e;

    typedef enum logic {
        STYLE_SPLIT  = 1'b0,
        STYLE_DIRSTB = 1'b1
    } bus_style_e;

    localparam int unsigned REG_OUTBOX = 0;
    localparam int unsigned REG_INBOX  = 1;
    localparam int unsigned REG_STATUS = 2;
    localparam int unsigned REG_GPIO   = 3;
endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpp_host_fsm.sv
module hpp_host_fsm
    import hpp_pkg::*;
#(
    parameter int unsigned AW = 2,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_raw,
    input  logic          s_cs_n,
    input  logic          s_ctl_a,
    input  logic          s_ctl_b,
    input  logic [AW-1:0] addr_raw,
    input  logic [DW-1:0] data_raw,
    output logic          armed_o,
    output bus_style_e    style_o,
    output logic          wr_commit_o,
    output logic          rd_done_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    hst_state_e state_q, state_d;
    bus_style_e style_q;
    logic       wr_act, rd_act, capture;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_comb begin
        if (style_q == STYLE_SPLIT) begin
            wr_act = !s_cs_n && !s_ctl_b;
            rd_act = !s_cs_n && !s_ctl_a;
        end else begin
            wr_act = !s_cs_n && !s_ctl_b && !s_ctl_a;
            rd_act = !s_cs_n && !s_ctl_b &&  s_ctl_a;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STRAP: state_d = S_IDLE;
            S_IDLE: begin
                if (wr_act)      state_d = S_WRITE;
                else if (rd_act) state_d = S_READ;
            end
            S_WRITE: if (!wr_act) state_d = S_IDLE;
            S_READ:  if (!rd_act) state_d = S_IDLE;
            default: state_d = S_STRAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_STRAP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 style_q <= STYLE_SPLIT;
        else if (state_q == S_STRAP) style_q <= bus_style_e'(strap_raw);
    end

    assign capture = (state_q == S_IDLE && (wr_act || rd_act)) ||
                     (state_q == S_WRITE && wr_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_raw;
            data_q <= data_raw;
        end
    end

    always_comb begin
        armed_o     = (state_q != S_STRAP);
        wr_commit_o = 1'b0;
        rd_done_o   = 1'b0;
        unique case (state_q)
            S_WRITE: wr_commit_o = !wr_act;
            S_READ:  rd_done_o   = !rd_act;
            default: ;
        endcase
    end

    assign style_o = style_q;
    assign addr_o  = addr_q;
    assign data_o  = data_q;

    // R2: style frozen once the strap state is left
    p_style_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_STRAP) |=> $stable(style_q));

    // R6: a deselected idle port stays idle
    p_idle_when_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && s_cs_n) |=> (state_q == S_IDLE));
endmodule

// File: rtl/hpp_regfile.sv
module hpp_regfile
    import hpp_pkg::*;
#(
    parameter int unsigned AW = 2,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic          rd_done,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          pin_level,
    input  logic          dsp_out_wr,
    input  logic [DW-1:0] dsp_out_data,
    input  logic          dsp_in_ack,
    output logic [DW-1:0] rd_data,
    output logic          out_pend,
    output logic [DW-1:0] in_data,
    output logic          in_full,
    output logic          gpio_val,
    output logic          gpio_oe
);
    localparam int unsigned PADW = DW - 3;

    logic [DW-1:0] out_data_q, in_data_q;
    logic          out_pend_q, in_full_q, gpio_val_q, gpio_oe_q;
    logic          wr_inbox, wr_gpio, rd_outbox;

    assign wr_inbox  = wr_commit && (acc_addr == AW'(REG_INBOX));
    assign wr_gpio   = wr_commit && (acc_addr == AW'(REG_GPIO));
    assign rd_outbox = rd_done   && (acc_addr == AW'(REG_OUTBOX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data_q <= '0;
            out_pend_q <= 1'b0;
        end else if (dsp_out_wr) begin
            out_data_q <= dsp_out_data;
            out_pend_q <= 1'b1;
        end else if (rd_outbox) begin
            out_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_data_q <= '0;
            in_full_q <= 1'b0;
        end else if (wr_inbox) begin
            in_data_q <= acc_data;
            in_full_q <= 1'b1;
        end else if (dsp_in_ack) begin
            in_full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpio_val_q <= 1'b0;
            gpio_oe_q  <= 1'b0;
        end else if (wr_gpio) begin
            gpio_val_q <= acc_data[0];
            gpio_oe_q  <= acc_data[1];
        end
    end

    always_comb begin
        unique case (rd_addr)
            AW'(REG_OUTBOX): rd_data = out_data_q;
            AW'(REG_INBOX):  rd_data = in_data_q;
            AW'(REG_STATUS): rd_data = {{PADW{1'b0}}, 1'b0, in_full_q, out_pend_q};
            default:         rd_data = {{PADW{1'b0}}, pin_level, gpio_oe_q, gpio_val_q};
        endcase
    end

    assign out_pend = out_pend_q;
    assign in_data  = in_data_q;
    assign in_full  = in_full_q;
    assign gpio_val = gpio_val_q;
    assign gpio_oe  = gpio_oe_q;

    // R8: a DSP post lands and raises pending
    p_post_sets_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_out_wr |=> (out_pend_q && out_data_q == $past(dsp_out_data)));

    // R9: finished outbox read without a racing post clears pending
    p_read_clears_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && acc_addr == AW'(REG_OUTBOX) && !dsp_out_wr) |=> !out_pend_q);

    // R10: host commit to the inbox sets full, even against an ack
    p_inbox_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && acc_addr == AW'(REG_INBOX)) |=> (in_full_q && in_data_q == $past(acc_data)));
endmodule

// File: rtl/hpp_host_port.sv
module hpp_host_port
    import hpp_pkg::*;
#(
    parameter int unsigned AW          = 2,
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hd_i,
    output logic [DW-1:0] hd_o,
    output logic          hd_oe,
    input  logic [AW-1:0] ha,
    input  logic          hcs_n,
    input  logic          hctl_a,
    input  logic          hctl_b,
    input  logic          strap_i,
    output logic          strap_o,
    output logic          strap_oe,
    output logic          irq_pull_low,
    input  logic          dsp_out_wr,
    input  logic [DW-1:0] dsp_out_data,
    input  logic          dsp_in_ack,
    output logic [DW-1:0] dsp_in_data,
    output logic          dsp_in_full
);
    localparam int unsigned NCTL = 3;

    logic [NCTL-1:0] ctl_sync;
    logic            armed, wr_commit, rd_done, out_pend, gpio_val, gpio_oe, rd_qual;
    bus_style_e      style;
    logic [AW-1:0]   acc_addr;
    logic [DW-1:0]   acc_data;

    hpp_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({hcs_n, hctl_a, hctl_b}),
        .q_o   (ctl_sync)
    );

    hpp_host_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_raw   (strap_i),
        .s_cs_n      (ctl_sync[2]),
        .s_ctl_a     (ctl_sync[1]),
        .s_ctl_b     (ctl_sync[0]),
        .addr_raw    (ha),
        .data_raw    (hd_i),
        .armed_o     (armed),
        .style_o     (style),
        .wr_commit_o (wr_commit),
        .rd_done_o   (rd_done),
        .addr_o      (acc_addr),
        .data_o      (acc_data)
    );

    hpp_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_commit    (wr_commit),
        .rd_done      (rd_done),
        .acc_addr     (acc_addr),
        .acc_data     (acc_data),
        .rd_addr      (ha),
        .pin_level    (strap_i),
        .dsp_out_wr   (dsp_out_wr),
        .dsp_out_data (dsp_out_data),
        .dsp_in_ack   (dsp_in_ack),
        .rd_data      (hd_o),
        .out_pend     (out_pend),
        .in_data      (dsp_in_data),
        .in_full      (dsp_in_full),
        .gpio_val     (gpio_val),
        .gpio_oe      (gpio_oe)
    );

    always_comb begin
        if (style == STYLE_SPLIT) rd_qual = !hctl_a;
        else                      rd_qual = !hctl_b && hctl_a;
    end

    assign hd_oe        = rst_n && armed && !hcs_n && rd_qual;
    assign strap_o      = gpio_val;
    assign strap_oe     = rst_n && armed && gpio_oe;
    assign irq_pull_low = out_pend;

    // R1: pads released while reset is low
    always_comb begin
        if (!rst_n) begin
            p_tristate_in_reset_r1: assert (!hd_oe && !strap_oe && !irq_pull_low);
        end
    end
endmodule

// File: tb/hpp_host_port_tb_top.sv
module hpp_host_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hd_i = '0;
    logic [7:0] hd_o;
    logic       hd_oe;
    logic [1:0] ha = '0;
    logic       hcs_n = 1'b1, hctl_a = 1'b1, hctl_b = 1'b1;
    logic       strap_i = 1'b0;
    logic       strap_o, strap_oe, irq_pull_low;
    logic       dsp_out_wr = 1'b0;
    logic [7:0] dsp_out_data = '0;
    logic       dsp_in_ack = 1'b0;
    logic [7:0] dsp_in_data;
    logic       dsp_in_full;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  cycles   = 0;
    logic cur_style = 1'b0;

    always #2 clk = ~clk;

    hpp_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe),
        .ha(ha), .hcs_n(hcs_n), .hctl_a(hctl_a), .hctl_b(hctl_b),
        .strap_i(strap_i), .strap_o(strap_o), .strap_oe(strap_oe),
        .irq_pull_low(irq_pull_low), .dsp_out_wr(dsp_out_wr),
        .dsp_out_data(dsp_out_data), .dsp_in_ack(dsp_in_ack),
        .dsp_in_data(dsp_in_data), .dsp_in_full(dsp_in_full)
    );

    typedef struct packed {
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{addr: 2'd1, wdata: 8'h5A, exp: 8'h5A},
        '{addr: 2'd0, wdata: 8'h77, exp: 8'h00},
        '{addr: 2'd1, wdata: 8'hA5, exp: 8'hA5},
        '{addr: 2'd2, wdata: 8'hFF, exp: 8'h02},
        '{addr: 2'd3, wdata: 8'hFF, exp: 8'h03},
        '{addr: 2'd3, wdata: 8'h02, exp: 8'h02}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_pins();
        hcs_n = 1'b1; hctl_a = 1'b1; hctl_b = 1'b1;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        ha = a; hd_i = d;
        hcs_n = 1'b0; hctl_b = 1'b0;
        hctl_a = (cur_style == 1'b0) ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
        hctl_b = 1'b1;
        repeat (5) @(negedge clk);
        idle_pins();
        repeat (2) @(negedge clk);
    endtask

    task automatic read_start(input logic [1:0] a, output logic [7:0] d, output logic oe);
        ha = a; hcs_n = 1'b0;
        if (cur_style == 1'b0) hctl_a = 1'b0;
        else begin hctl_a = 1'b1; hctl_b = 1'b0; end
        #1;
        d = hd_o; oe = hd_oe;
        @(negedge clk);
        repeat (3) @(negedge clk);
        if (cur_style == 1'b0) hctl_a = 1'b1;
        else                   hctl_b = 1'b1;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
        read_start(a, d, oe);
        repeat (5) @(negedge clk);
        idle_pins();
        repeat (2) @(negedge clk);
    endtask

    task automatic apply_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_i = strap;
        idle_pins();
        repeat (2) @(negedge clk);
        hcs_n = 1'b0; hctl_a = 1'b0; hctl_b = 1'b0;
        #1;
        check("R1 hd_oe in reset", {7'd0, hd_oe}, 8'h00);
        check("R1 strap_oe in reset", {7'd0, strap_oe}, 8'h00);
        check("R1 irq in reset", {7'd0, irq_pull_low}, 8'h00);
        idle_pins();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cur_style = strap;
    endtask

    task automatic run_table();
        logic [7:0] d;
        logic       oe;
        logic [7:0] e;
        for (int i = 0; i < 6; i++) begin
            do_write(VECS[i].addr, VECS[i].wdata);
            do_read(VECS[i].addr, d, oe);
            e = VECS[i].exp;
            if (VECS[i].addr == 2'd3) e = e | {5'd0, strap_i, 2'b00};
            check(cur_style ? "R5 R7 table readback" : "R3 R4 R7 table readback", d, e);
            check(cur_style ? "R5 read enable" : "R4 read enable", {7'd0, oe}, 8'h01);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;

        // split style
        apply_reset(1'b0);
        do_read(2'd1, d, oe);
        check("R1 inbox after reset", d, 8'h00);
        do_read(2'd2, d, oe);
        check("R1 status after reset", d, 8'h00);
        do_read(2'd3, d, oe);
        check("R1 gpio after reset", d, 8'h00);

        run_table();
        check("R11 strap_o", {7'd0, strap_o}, 8'h00);
        check("R11 strap_oe", {7'd0, strap_oe}, 8'h01);
        do_write(2'd3, 8'h03);
        check("R11 strap_o high", {7'd0, strap_o}, 8'h01);

        // write strobe with select high is ignored
        ha = 2'd1; hd_i = 8'hEE; hctl_b = 1'b0; hctl_a = 1'b0;
        #1;
        check("R6 no drive when deselected", {7'd0, hd_oe}, 8'h00);
        repeat (4) @(negedge clk);
        idle_pins();
        repeat (5) @(negedge clk);
        do_read(2'd1, d, oe);
        check("R6 inbox unchanged", d, 8'hA5);

        // strap changes after latch do not alter style
        strap_i = 1'b1;
        do_read(2'd1, d, oe);
        check("R2 split style kept", d, 8'hA5);
        strap_i = 1'b0;

        // inbox flag and DSP ack
        check("R10 dsp_in_full", {7'd0, dsp_in_full}, 8'h01);
        check("R10 dsp_in_data", dsp_in_data, 8'hA5);
        dsp_in_ack = 1'b1; @(negedge clk); dsp_in_ack = 1'b0; @(negedge clk);
        check("R10 full cleared", {7'd0, dsp_in_full}, 8'h00);

        // outbox and interrupt
        dsp_out_data = 8'hC3; dsp_out_wr = 1'b1; @(negedge clk); dsp_out_wr = 1'b0;
        check("R8 irq raised", {7'd0, irq_pull_low}, 8'h01);
        do_read(2'd2, d, oe);
        check("R8 status pending", d, 8'h01);
        do_write(2'd0, 8'h11);
        do_read(2'd0, d, oe);
        check("R7 outbox read-only", d, 8'hC3);
        check("R9 irq released", {7'd0, irq_pull_low}, 8'h00);

        // race: post in the clock the read finishes
        dsp_out_data = 8'h21; dsp_out_wr = 1'b1; @(negedge clk); dsp_out_wr = 1'b0;
        read_start(2'd0, d, oe);
        @(posedge clk); @(posedge clk); @(negedge clk);
        dsp_out_data = 8'h3C; dsp_out_wr = 1'b1;
        @(negedge clk); dsp_out_wr = 1'b0;
        repeat (4) @(negedge clk);
        idle_pins();
        repeat (2) @(negedge clk);
        check("R9 race keeps pending", {7'd0, irq_pull_low}, 8'h01);
        do_read(2'd0, d, oe);
        check("R9 race new byte", d, 8'h3C);
        check("R9 cleared after plain read", {7'd0, irq_pull_low}, 8'h00);

        // direction plus strobe style
        apply_reset(1'b1);
        check("R2 gpio reset in new run", {7'd0, strap_oe}, 8'h00);
        ha = 2'd1; hcs_n = 1'b0; hctl_a = 1'b0; hctl_b = 1'b1;
        #1;
        check("R5 no drive with direction low", {7'd0, hd_oe}, 8'h00);
        idle_pins();
        @(negedge clk);
        run_table();
        strap_i = 1'b0;
        do_read(2'd1, d, oe);
        check("R2 direction style kept", d, 8'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule